// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block paces a UART's bit timing with a fractional phase accumulator rather than an integer clock divider. A programmed increment is added into a 20-bit phase register on every clock while the line is switched on. Each time the sum carries out of the top bit, the block raises a tick for exactly one cycle. The average tick rate is therefore the clock frequency times the increment divided by 2^20. To reach a baud rate B from a clock F, software programs round(B · 2^20 / F). Serialiser, deserialiser and oversampling logic sit downstream and see only the tick.

The block also holds the line control settings that travel with the rate: a transmit enable, a receive enable, a parity enable, and a parity sense bit (1 selects odd parity, 0 selects even). All of these, together with the increment, are loaded by one configuration write. A write is a single-cycle strobe with its fields present in the same cycle; there is no handshake. An increment of zero is not a legal rate, so a write that carries one is discarded in full. The control pins are plain levels and the tick is a plain pulse, so no valid/ready interface applies.

Top module: `nco_baud_tick`

## Requirements
- R1: While reset is asserted and after its release, the tick and all four control outputs are 0.
- R2: A write with a non-zero increment loads the increment and all four control fields at the clock edge that samples it, and the control outputs show the new values from that edge onward.
- R3: A write whose increment is zero is ignored as a whole: the control outputs keep their values and the tick pattern continues exactly as if no write had occurred.
- R4: While either enable is 1, each clock edge adds the increment into an ACC_W-bit phase (ACC_W defaults to 20). The tick is 1 for the cycle after each addition that carries out of bit ACC_W-1. Over N additions starting from phase 0, exactly floor(N·incr / 2^ACC_W) ticks occur.
- R5: While both enables are 0, the phase is held at zero and no tick is produced. Turning an enable back on restarts the count from phase 0.
- R6: A new increment is used from the first addition after the edge that loads it, and the phase is not cleared. The addition at the loading edge itself still uses the old increment, so a wrap in that cycle still ticks.
- R7: The tick is never 1 in two consecutive cycles. This holds because the increment field (INC_W bits, default 16) is narrower than the phase.
- R8: The parity enable and parity sense bits are passed to their outputs unchanged and have no effect on tick timing.
- R9: Either enable alone is enough to run the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_incr_i | input | INC_W | Phase increment; zero rejects the write |
| cfg_tx_en_i | input | 1 | Transmit enable to load |
| cfg_rx_en_i | input | 1 | Receive enable to load |
| cfg_par_en_i | input | 1 | Parity enable to load |
| cfg_par_odd_i | input | 1 | Parity sense to load: 1 odd, 0 even |
| tx_en_o | output | 1 | Registered transmit enable |
| rx_en_o | output | 1 | Registered receive enable |
| par_en_o | output | 1 | Registered parity enable |
| par_odd_o | output | 1 | Registered parity sense |
| baud_tick_o | output | 1 | One-cycle pulse on each phase wrap |

## Verification
The functions that can fall in the same cycle are a configuration write and a phase wrap. The write may change the increment, switch the line off, or carry an illegal zero increment. To provoke this, the bench runs a reference phase alongside the design and waits for the cycle whose next addition will carry. It then places the write on exactly that edge. The result is judged cycle by cycle against the reference: the wrap must still tick under the old increment, the new increment must govern the next addition with the phase kept, and a zero-increment write must leave the tick train undisturbed. An exhaustive sweep of every legal increment on a narrowed accumulator checks the tick count against floor(N·incr / 2^ACC_W).

// File: rtl/nco_baud_pkg.sv
package nco_baud_pkg;

  // Line control settings loaded together with the increment.
  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic par_en;
    logic par_odd;   // 1: odd parity, 0: even parity
  } line_ctrl_t;

  localparam line_ctrl_t LINE_CTRL_RESET = '{tx_en: 1'b0, rx_en: 1'b0,
                                             par_en: 1'b0, par_odd: 1'b0};

endpackage

// File: rtl/nco_cfg_reg.sv
module nco_cfg_reg
  import nco_baud_pkg::*;
#(
  parameter int              INC_W      = 16,
  parameter logic [INC_W-1:0] RESET_INCR = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [INC_W-1:0] incr_i,
  input  line_ctrl_t       ctrl_i,
  output logic [INC_W-1:0] incr_o,
  output line_ctrl_t       ctrl_o,
  output logic             run_o
);

  logic             accept;
  logic [INC_W-1:0] incr_q;
  line_ctrl_t       ctrl_q;

  // A zero increment is not a legal rate: drop the whole write.
  assign accept = we_i && (incr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      incr_q <= RESET_INCR;
      ctrl_q <= LINE_CTRL_RESET;
    end else if (accept) begin
      incr_q <= incr_i;
      ctrl_q <= ctrl_i;
    end
  end

  assign incr_o = incr_q;
  assign ctrl_o = ctrl_q;
  assign run_o  = ctrl_q.tx_en | ctrl_q.rx_en;

  // R3
  zero_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && incr_i == '0) |=> ($stable(incr_q) && $stable(ctrl_q)));

  // R2
  write_loaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && incr_i != '0) |=> (incr_q == $past(incr_i) && ctrl_q == $past(ctrl_i)));

  // R3
  incr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incr_q != '0);

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 20,
  parameter int INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [INC_W-1:0] incr_i,
  output logic             tick_o
);

  localparam int PAD_W = ACC_W - INC_W;

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   sum_w;
  logic             tick_q;

  assign sum_w = {1'b0, phase_q} + {1'b0, {PAD_W{1'b0}}, incr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else if (run_i) begin
      phase_q <= sum_w[ACC_W-1:0];
      tick_q  <= sum_w[ACC_W];
    end else begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R5
  idle_phase_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (phase_q == '0 && !tick_q));

  // R7
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);

  // R4
  tick_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(run_i));

  // R4
  wrap_lowers_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (phase_q < $past(phase_q)));

endmodule

// File: rtl/nco_baud_tick.sv
module nco_baud_tick
  import nco_baud_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [INC_W-1:0] cfg_incr_i,
  input  logic             cfg_tx_en_i,
  input  logic             cfg_rx_en_i,
  input  logic             cfg_par_en_i,
  input  logic             cfg_par_odd_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             par_en_o,
  output logic             par_odd_o,
  output logic             baud_tick_o
);

  line_ctrl_t       ctrl_in;
  line_ctrl_t       ctrl_q;
  logic [INC_W-1:0] incr_q;
  logic             run;

  assign ctrl_in = '{tx_en: cfg_tx_en_i, rx_en: cfg_rx_en_i,
                     par_en: cfg_par_en_i, par_odd: cfg_par_odd_i};

  nco_cfg_reg #(
    .INC_W      (INC_W),
    .RESET_INCR ({{(INC_W-1){1'b0}}, 1'b1})
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .incr_i (cfg_incr_i),
    .ctrl_i (ctrl_in),
    .incr_o (incr_q),
    .ctrl_o (ctrl_q),
    .run_o  (run)
  );

  nco_phase_acc #(
    .ACC_W (ACC_W),
    .INC_W (INC_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .incr_i (incr_q),
    .tick_o (baud_tick_o)
  );

  assign tx_en_o   = ctrl_q.tx_en;
  assign rx_en_o   = ctrl_q.rx_en;
  assign par_en_o  = ctrl_q.par_en;
  assign par_odd_o = ctrl_q.par_odd;

  // R9
  run_follows_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o || rx_en_o) == run);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!baud_tick_o && !tx_en_o && !rx_en_o));

endmodule

// File: tb/nco_baud_tick_test.sv
`timescale 1ns/1ps
module nco_baud_tick_test;

  localparam int AW   = 10;
  localparam int IW   = 8;
  localparam int MODV = 1 << AW;
  localparam int RUNN = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_incr = '0;
  logic          cfg_tx = 1'b0, cfg_rx = 1'b0, cfg_pe = 1'b0, cfg_po = 1'b0;
  logic          tx_en, rx_en, par_en, par_odd, tick;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state computed from the requirements.
  int ref_p = 0, ref_inc = 1, ref_tick = 0, prev_tick = 0;
  bit ref_tx = 0, ref_rx = 0, ref_pe = 0, ref_po = 0;

  always #10 clk = ~clk;   // 50 MHz

  nco_baud_tick #(.ACC_W(AW), .INC_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_incr_i(cfg_incr),
    .cfg_tx_en_i(cfg_tx), .cfg_rx_en_i(cfg_rx), .cfg_par_en_i(cfg_pe),
    .cfg_par_odd_i(cfg_po), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .par_en_o(par_en), .par_odd_o(par_odd), .baud_tick_o(tick));

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One clock: drive at negedge, update reference after the edge, compare at negedge.
  task automatic step(input bit we, input int inc, input bit tx, input bit rx,
                      input bit pe, input bit po, input string req);
    int nxt;
    cfg_we = we; cfg_incr = inc[IW-1:0];
    cfg_tx = tx; cfg_rx = rx; cfg_pe = pe; cfg_po = po;
    @(posedge clk); #1;
    if (ref_tx || ref_rx) begin
      nxt = ref_p + ref_inc;
      ref_tick = (nxt >= MODV) ? 1 : 0;
      ref_p = nxt % MODV;
    end else begin
      ref_p = 0; ref_tick = 0;
    end
    if (we && inc != 0) begin
      ref_inc = inc; ref_tx = tx; ref_rx = rx; ref_pe = pe; ref_po = po;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    chk(req, tick, ref_tick);
    chk("R2", {tx_en, rx_en}, {ref_tx, ref_rx});
    chk("R8", {par_en, par_odd}, {ref_pe, ref_po});
    if (prev_tick == 1 && tick) chk("R7", tick, 0);
    prev_tick = tick;
  endtask

  initial begin
    #(150000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int cnt;
    int exp_cnt;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk("R1", {tick, tx_en, rx_en, par_en, par_odd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {tick, tx_en, rx_en, par_en, par_odd}, 0);
    // R5: idle after reset produces nothing
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0, "R5");

    // R4/R9 sweep over every legal increment
    for (int i = 1; i < (1 << IW); i++) begin
      bit tx_sel = i[0];
      step(1, i, tx_sel, !tx_sel, i[1], i[2], "R9");
      cnt = 0;
      for (int k = 0; k < RUNN; k++) begin
        step(0, 0, 0, 0, 0, 0, "R4");
        cnt += tick;
      end
      exp_cnt = (RUNN * i) / MODV;
      chk("R4", cnt, exp_cnt);
      step(1, i, 0, 0, 0, 0, "R5");
      step(0, 0, 0, 0, 0, 0, "R5");
      chk("R5", tick, 0);
    end

    // R6: change increment mid-run, phase kept
    step(1, 100, 1, 1, 1, 0, "R6");
    for (int k = 0; k < 37; k++) step(0, 0, 0, 0, 0, 0, "R6");
    step(1, 37, 1, 1, 1, 0, "R6");
    for (int k = 0; k < 100; k++) step(0, 0, 0, 0, 0, 0, "R6");

    // R6: increment write lands on a wrapping edge
    step(1, 200, 1, 0, 0, 1, "R6");
    for (int k = 0; k < 20 && (ref_p + ref_inc) < MODV; k++)
      step(0, 0, 0, 0, 0, 0, "R6");
    step(1, 7, 1, 0, 0, 1, "R6");
    chk("R6", tick, 1);
    for (int k = 0; k < 400; k++) step(0, 0, 0, 0, 0, 0, "R6");

    // R3: zero-increment write ignored, also on a wrapping edge
    step(1, 150, 0, 1, 1, 1, "R3");
    for (int k = 0; k < 20 && (ref_p + ref_inc) < MODV; k++)
      step(0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0, "R3");
    chk("R3", tick, 1);
    chk("R3", {tx_en, rx_en, par_en, par_odd}, 4'b0111);
    for (int k = 0; k < 50; k++) step(0, 0, 0, 0, 0, 0, "R3");

    // R5: disable on a wrapping edge, then restart from zero phase
    for (int k = 0; k < 20 && (ref_p + ref_inc) < MODV; k++)
      step(0, 0, 0, 0, 0, 0, "R5");
    step(1, 150, 0, 0, 0, 0, "R5");
    chk("R5", tick, 1);
    step(0, 0, 0, 0, 0, 0, "R5");
    chk("R5", tick, 0);
    step(1, 255, 1, 0, 0, 0, "R5");
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 0, 0, 0, "R5");
      cnt += tick;
    end
    chk("R5", cnt, 0);
    step(0, 0, 0, 0, 0, 0, "R5");
    chk("R5", tick, 1);

    summary();
  end

endmodule